// File: doc/BRIEF.md
# Registered Unsigned Carry-Save Array Multiplier

This block multiplies two unsigned operands and returns the full-width exact product. Each operand bit pair is ANDed to form one partial-product bit, with no Booth recoding. The shifted partial-product rows are then folded by stages of 3:2 full-adder compressors until a single sum row and a single carry row remain. A three-section carry-select adder adds those two rows. Its lowest section is a plain ripple adder. Each upper section computes two sums in parallel, one for each possible incoming carry, and picks the right one when the carry arrives.

The operands are captured in one register stage, and the product is captured in one output register. All arithmetic between them is combinational. A pair presented before a rising edge therefore appears on the output after the following rising edge. A new pair can be accepted on every clock. The section widths of the final adder are parameters, with the upper sections wider than the lower ones so that the carry chains finish at about the same time.

Top module: `csa_mul`

## Requirements
- R1: `product` equals `op_a * op_b` as an exact unsigned 16-bit value. It appears after the second rising edge following the cycle in which the pair is presented.
- R2: While `rst` is high at a rising edge, the operand registers and `product` are cleared to 0. After release, `product` stays 0 until a new pair has passed through both register stages.
- R3: The carry-save reduction leaves two rows whose sum, modulo 2^16, equals the product of the registered operands.
- R4: If either operand is 0, the product is 0 (0×0, 0×1, 1×0).
- R5: The carry-select final adder's result equals the sum of the two reduced rows.
- R6: The most significant product bit is kept: 255×255 gives 65025 (0xFE01), and the final adder never produces a carry out of bit 15.
- R7: Multiplying by 1 or by a power of two gives the other operand, or that operand shifted: 1×1=1, 1×2=2, 2×1=2, 1×128=128, 128×1=128, 1×255=255, 255×1=255.
- R8: A different pair can be presented on every clock. The products come out one per clock, in the same order. When the registered operands do not change, the product holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| product | output | 16 | Registered unsigned product |

## Verification
The zero-operand cases show whether the partial-product AND gating works. The multiply-by-one and power-of-two cases place a single partial-product row at every shift position, which exposes a misaligned row or a dropped column. The 255×255 case fills every column of the matrix. It drives the longest carry chains through the compressors and through each carry-select section, so a lost top bit or a wrong section multiplexer selection shows up there. Seeded random pairs, applied back to back on every clock, mix carry patterns across section boundaries and confirm that the one-clock spacing between products holds.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;
  // Single-bit full-adder equations shared by compressors and ripple sections.
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/csa_mul_tree.sv
// Partial-product generation plus carry-save reduction down to two rows.
module csa_mul_tree #(
  parameter int AW = 8,
  parameter int BW = 8,
  localparam int PW = AW + BW,
  localparam int NST = BW - 2
) (
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [PW-1:0] row_s,
  output logic [PW-1:0] row_c
);
  import csa_mul_pkg::*;

  logic [PW-1:0] pp    [BW];
  logic [PW-1:0] s_acc [NST];
  logic [PW-1:0] c_acc [NST];

  // Row j holds a[i]&b[j] at weight 2^(i+j).
  for (genvar j = 0; j < BW; j++) begin : g_pp
    assign pp[j] = PW'(a & {AW{b[j]}}) << j;
  end

  // Stage k folds one more partial-product row into the sum/carry pair.
  for (genvar k = 0; k < NST; k++) begin : g_stage
    logic [PW-1:0] x, y, z, cy;
    if (k == 0) begin : g_first
      assign x = pp[0];
      assign y = pp[1];
    end else begin : g_next
      assign x = s_acc[k-1];
      assign y = c_acc[k-1];
    end
    assign z = pp[k+2];
    for (genvar i = 0; i < PW; i++) begin : g_col
      assign s_acc[k][i] = fa_sum(x[i], y[i], z[i]);
      assign cy[i]       = fa_carry(x[i], y[i], z[i]);
    end
    // Carries move one column up; the carry out of the top column is beyond the product width.
    assign c_acc[k] = {cy[PW-2:0], 1'b0};
  end

  assign row_s = s_acc[NST-1];
  assign row_c = c_acc[NST-1];
endmodule

// File: rtl/csa_mul_rca.sv
// Ripple-carry section built from full adders.
module csa_mul_rca #(
  parameter int N = 4
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         cin,
  output logic [N-1:0] s,
  output logic         cout
);
  import csa_mul_pkg::*;

  logic [N:0] c;
  assign c[0] = cin;
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign s[i]   = fa_sum(x[i], y[i], c[i]);
    assign c[i+1] = fa_carry(x[i], y[i], c[i]);
  end
  assign cout = c[N];
endmodule

// File: rtl/csa_mul_csel.sv
// Three-section carry-select adder: ripple low section, dual-rail upper sections.
module csa_mul_csel #(
  parameter int W  = 16,
  parameter int W0 = 4,
  parameter int W1 = 5,
  localparam int W2 = W - W0 - W1,
  localparam int B1 = W0,
  localparam int B2 = W0 + W1
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic          c0;
  logic [W1-1:0] s1_lo, s1_hi;
  logic          c1_lo, c1_hi, c1;
  logic [W2-1:0] s2_lo, s2_hi;
  logic          c2_lo, c2_hi;

  csa_mul_rca #(.N(W0)) u_sec0 (
    .x(x[W0-1:0]), .y(y[W0-1:0]), .cin(1'b0), .s(sum[W0-1:0]), .cout(c0));

  csa_mul_rca #(.N(W1)) u_sec1_lo (
    .x(x[B2-1:B1]), .y(y[B2-1:B1]), .cin(1'b0), .s(s1_lo), .cout(c1_lo));
  csa_mul_rca #(.N(W1)) u_sec1_hi (
    .x(x[B2-1:B1]), .y(y[B2-1:B1]), .cin(1'b1), .s(s1_hi), .cout(c1_hi));

  csa_mul_rca #(.N(W2)) u_sec2_lo (
    .x(x[W-1:B2]), .y(y[W-1:B2]), .cin(1'b0), .s(s2_lo), .cout(c2_lo));
  csa_mul_rca #(.N(W2)) u_sec2_hi (
    .x(x[W-1:B2]), .y(y[W-1:B2]), .cin(1'b1), .s(s2_hi), .cout(c2_hi));

  // Carry arriving from below picks the precomputed result.
  assign sum[B2-1:B1] = c0 ? s1_hi : s1_lo;
  assign c1           = c0 ? c1_hi : c1_lo;
  assign sum[W-1:B2]  = c1 ? s2_hi : s2_lo;
  assign cout         = c1 ? c2_hi : c2_lo;
endmodule

// File: rtl/csa_mul.sv
// Registered unsigned multiplier: input regs -> CSA tree -> carry-select CPA -> output reg.
module csa_mul #(
  parameter int AW   = 8,
  parameter int BW   = 8,
  parameter int SEC0 = 4,
  parameter int SEC1 = 5,
  localparam int PW  = AW + BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] op_a,
  input  logic [BW-1:0] op_b,
  output logic [PW-1:0] product
);
  logic [AW-1:0] a_q;
  logic [BW-1:0] b_q;
  logic [PW-1:0] row_s, row_c;
  logic [PW-1:0] cpa_sum;
  logic          cpa_cout;
  logic [PW-1:0] rows_total;   // behavioural view of the two-row sum, for checks
  logic [PW-1:0] exact_now;    // behavioural product of registered operands, for checks

  function automatic logic [PW-1:0] exact_product(input logic [AW-1:0] a, input logic [BW-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      b_q     <= '0;
      product <= '0;
    end else begin
      a_q     <= op_a;
      b_q     <= op_b;
      product <= cpa_sum;
    end
  end

  csa_mul_tree #(.AW(AW), .BW(BW)) u_tree (
    .a(a_q), .b(b_q), .row_s(row_s), .row_c(row_c));

  csa_mul_csel #(.W(PW), .W0(SEC0), .W1(SEC1)) u_cpa (
    .x(row_s), .y(row_c), .sum(cpa_sum), .cout(cpa_cout));

  assign rows_total = row_s + row_c;
  assign exact_now  = exact_product(a_q, b_q);

  // R3: reduced rows carry the full product
  a_r3_rows_match: assert property (@(posedge clk) disable iff (rst)
    rows_total == exact_now);

  // R5: carry-select adder agrees with the two-row sum
  a_r5_cpa_match: assert property (@(posedge clk) disable iff (rst)
    cpa_sum == rows_total);

  // R6: product always fits; no carry escapes the final adder
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !cpa_cout);

  // R1: registered output is the product of the previous registered operands
  a_r1_product: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> product == exact_product($past(a_q), $past(b_q)));

  // R4: a zero operand yields a zero product
  a_r4_zero: assert property (@(posedge clk) disable iff (rst)
    (a_q == '0 || b_q == '0) |=> product == '0);

  // R7: multiplying by one passes the other operand through
  a_r7_identity: assert property (@(posedge clk) disable iff (rst)
    (a_q == AW'(1)) |=> product == PW'($past(b_q)));

  // R8: steady operands keep the product steady
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    ($stable(a_q) && $stable(b_q)) |=> $stable(product));
endmodule

// File: tb/csa_mul_test.sv
module csa_mul_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic [15:0] product;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [15:0] exp_d1, exp_d2;
  bit          v1, v2;
  string       tag_d1, tag_d2;

  always #5 clk = ~clk;

  csa_mul uut (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .product(product));

  // Shift-and-add reference, independent of the design's structure.
  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc = '0;
    for (int i = 0; i < 8; i++)
      if (b[i]) acc = acc + ({8'h00, a} << i);
    return acc;
  endfunction

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: product=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // One clock per pair; the pair driven two negedges ago is checked now.
  task automatic step(input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    if (v2) check(product, exp_d2, tag_d2);
    exp_d2 = exp_d1; v2 = v1; tag_d2 = tag_d1;
    exp_d1 = ref_mul(a, b); v1 = 1'b1; tag_d1 = tag;
    op_a = a; op_b = b;
  endtask

  task automatic drain();
    repeat (2) begin
      @(negedge clk);
      if (v2) check(product, exp_d2, tag_d2);
      exp_d2 = exp_d1; v2 = v1; tag_d2 = tag_d1; v1 = 1'b0;
    end
  endtask

  initial begin
    v1 = 1'b0; v2 = 1'b0;
    void'($urandom(32'd20150201));
    repeat (3) @(negedge clk);
    check(product, 16'd0, "R2 reset value");
    op_a = 8'hFF; op_b = 8'hFF;
    @(negedge clk);
    check(product, 16'd0, "R2 held in reset");
    op_a = 8'd0; op_b = 8'd0;
    rst = 1'b0;

    // Directed corner cases
    step(8'd0,   8'd0,   "R4 0x0");
    step(8'd0,   8'd1,   "R4 0x1");
    step(8'd1,   8'd0,   "R4 1x0");
    step(8'd1,   8'd1,   "R7 1x1");
    step(8'd1,   8'd2,   "R7 1x2");
    step(8'd2,   8'd1,   "R7 2x1");
    step(8'd1,   8'd128, "R7 1x128");
    step(8'd128, 8'd1,   "R7 128x1");
    step(8'd1,   8'd255, "R7 1x255");
    step(8'd255, 8'd1,   "R7 255x1");
    step(8'd255, 8'd255, "R6 255x255");
    step(8'hAA,  8'h55,  "R1 alternating bits");
    step(8'hFF,  8'h80,  "R1 full by top bit");
    step(8'h0F,  8'hF0,  "R1 split nibbles");
    drain();

    // Held operands: product stays put
    step(8'd37, 8'd201, "R8 hold");
    step(8'd37, 8'd201, "R8 hold");
    step(8'd37, 8'd201, "R8 hold");
    drain();

    // Back-to-back random pairs
    for (int n = 0; n < 300; n++)
      step(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), "R1 R3 R5 R8 random");
    drain();

    // Reset in mid-stream clears output and operand registers
    @(negedge clk);
    op_a = 8'd200; op_b = 8'd199;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(product, 16'd0, "R2 mid-run reset");
    rst = 1'b0;
    op_a = 8'd3; op_b = 8'd3;
    @(negedge clk);
    check(product, 16'd0, "R2 first cycle after release");
    @(negedge clk);
    check(product, 16'd9, "R2 R1 first product after release");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: product=%0d expected=completion", product);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule